// File: doc/BRIEF.md
# Overlapping 1011 Serial Pattern Detector

This block watches a one-bit serial stream, sampling it on every rising clock edge, and raises a single-bit flag when the four most recently sampled bits are 1, 0, 1, 1 (oldest first). It is a four-state Mealy machine. The flag is computed from the current progress state and the incoming bit, and is then captured in its own flip-flop. As a result the flag moves only at a rising edge and is free of glitches between edges. The cost is that the flag appears just after the edge that sampled the completing bit.

Detection never restarts from scratch after a hit. The completing 1 is kept as the first bit of the next attempt, so overlapping occurrences are all reported. The block takes an asynchronous active-low reset. Reset release is synchronised internally, so the machine starts sampling a fixed number of edges after the reset pin rises.

Top module: `seqdet_1011`

## Requirements
- R1: `hit` is 1 during the cycle after a rising edge exactly when the bit sampled at that edge and the bits sampled at the three edges before it are 1, 0, 1, 1, oldest first.
- R2: `hit` is 0 after every edge where the last four sampled bits differ from 1, 0, 1, 1. This includes all edges where fewer than four bits have been taken since reset.
- R3: Overlapping occurrences are all found. The stream 1,0,1,1,0,1,1 gives a pulse after the 4th bit and after the 7th bit, and none elsewhere.
- R4: The completing 1 of a match starts the next attempt. After 1,0,1,1 the continuation 1,0,1,1 gives a second pulse after the 8th bit, while the continuation 0,0,1,1 gives none.
- R5: While `rst_n` is low, `hit` is 0 and the progress state is idle. After `rst_n` rises, the first RST_SYNC_STAGES rising edges are ignored, and any partial pattern seen before reset is forgotten.
- R6: `hit` changes only at a rising edge of `clk`. A change of `din` between edges does not move it.
- R7: Partial progress follows the pattern's self-overlap. A second 1 after a leading 1 keeps one 1 of progress, so 1,1,0,1,1 matches on the 5th bit. A 0 after 1,0 discards all progress, so 1,0,0,1,1 does not match. A 0 after 1,0,1 keeps 1,0 of progress, so 1,0,1,0,1,1 matches on the 6th bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `din` is sampled and `hit` updated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| din | input | 1 | Serial data bit |
| hit | output | 1 | Registered detect flag, high for one cycle per completed match |

## Verification
A corrupted progress state appears at the ports the next time the stream could complete or miss a match. Whether that takes one edge or up to four, the flag then disagrees with a four-bit window of the stream. The bench therefore streams every 12-bit word back to back, with no reset between words, so that each of the four states meets both input values from every history. It compares the flag with a shift-register reference after every edge. Directed streams separate the self-overlap cases (kept 1, kept 1-0, discarded progress), which a wrong transition would show within one or two edges. A reset applied in the middle of a partial pattern shows whether stale progress survives reset.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  // Progress states: how much of 1,0,1,1 has been seen.
  localparam int unsigned STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    S_IDLE   = 2'b00,  // nothing useful
    S_GOT1   = 2'b01,  // "1"
    S_GOT10  = 2'b10,  // "1,0"
    S_GOT101 = 2'b11   // "1,0,1"
  } prog_state_e;

endpackage

// File: rtl/seqdet_rst_sync.sv
module seqdet_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q;
  logic [N-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[N-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[N-1];

endmodule

// File: rtl/seqdet_next.sv
module seqdet_next
  import seqdet_pkg::*;
(
  input  prog_state_e state_i,
  input  logic        din_i,
  output prog_state_e state_o,
  output logic        hit_o
);

  always_comb begin
    state_o = S_IDLE;
    hit_o   = 1'b0;
    unique case (state_i)
      S_IDLE:   state_o = din_i ? S_GOT1 : S_IDLE;
      S_GOT1:   state_o = din_i ? S_GOT1 : S_GOT10;
      S_GOT10:  state_o = din_i ? S_GOT101 : S_IDLE;
      S_GOT101: begin
        state_o = din_i ? S_GOT1 : S_GOT10;
        hit_o   = din_i;
      end
      default:  state_o = S_IDLE;
    endcase
  end

endmodule

// File: rtl/seqdet_regs.sv
module seqdet_regs
  import seqdet_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_en,
  input  prog_state_e state_d,
  input  logic        hit_d,
  output prog_state_e state_q,
  output logic        hit_q
);

  prog_state_e state_nxt;
  logic        hit_nxt;

  // Enable written out: hold when load_en is low.
  always_comb begin
    state_nxt = load_en ? state_d : state_q;
    hit_nxt   = load_en ? hit_d   : hit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_nxt;
      hit_q   <= hit_nxt;
    end
  end

endmodule

// File: rtl/seqdet_1011.sv
module seqdet_1011
  import seqdet_pkg::*;
#(
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic hit
);

  logic        core_rst_n;
  prog_state_e state_q;
  prog_state_e state_d;
  logic        hit_d;
  logic        hit_q;

  seqdet_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (core_rst_n)
  );

  seqdet_next u_next (
    .state_i (state_q),
    .din_i   (din),
    .state_o (state_d),
    .hit_o   (hit_d)
  );

  seqdet_regs u_regs (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .load_en (1'b1),
    .state_d (state_d),
    .hit_d   (hit_d),
    .state_q (state_q),
    .hit_q   (hit_q)
  );

  assign hit = hit_q;

endmodule

// File: rtl/seqdet_1011_chk.sv
module seqdet_1011_chk
  import seqdet_pkg::*;
(
  input logic                clk,
  input logic                core_rst_n,
  input logic                din,
  input logic                hit,
  input logic [STATE_W-1:0]  state
);

  logic [2:0] seen_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      seen_q <= 3'd0;
    end else if (seen_q != 3'd4) begin
      seen_q <= seen_q + 3'd1;
    end
  end

  // R5: reset holds the flag low and the progress idle
  always @(negedge clk) begin
    if (!core_rst_n) begin
      p_reset_idle_r5: assert (hit == 1'b0 && state == S_IDLE)
        else $error("reset state wrong");
    end
  end

  // R1: a raised flag implies the last four sampled bits were 1,0,1,1
  p_hit_tail_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (hit && seen_q == 3'd4) |->
      ($past(din, 1) && $past(din, 2) && !$past(din, 3) && $past(din, 4)));

  // R4: a match leaves one 1 of progress
  p_match_keeps_one_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    hit |-> (state == S_GOT1));

  // R2: idle with a 0 stays idle and silent
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state == S_IDLE && !din) |=> (state == S_IDLE && !hit));

  // R7: 1 after 1 keeps progress at one 1
  p_keep_one_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state == S_GOT1 && din) |=> (state == S_GOT1 && !hit));

  // R7: 0 after 1,0 discards progress
  p_drop_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state == S_GOT10 && !din) |=> (state == S_IDLE && !hit));

  // R7: 0 after 1,0,1 keeps 1,0
  p_back_to_10_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state == S_GOT101 && !din) |=> (state == S_GOT10 && !hit));

endmodule

bind seqdet_1011 seqdet_1011_chk i_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .din        (din),
  .hit        (hit),
  .state      (state_q)
);

// File: tb/test_seqdet_1011.sv
`timescale 1ns/1ps
module test_seqdet_1011;

  localparam int unsigned SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic din = 1'b0;
  logic hit;

  int total = 0;
  int bad = 0;
  logic [3:0] hist = 4'b0000;

  always #4 clk = ~clk;

  seqdet_1011 #(.RST_SYNC_STAGES(SYNC)) i_seqdet_1011 (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .hit   (hit)
  );

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One serial bit: drive at negedge, sample after the rising edge.
  task automatic step(input logic b, output logic h);
    logic prev;
    logic exp;
    @(negedge clk);
    prev = hit;
    din = b;
    #2;
    check(hit, prev, "R6", "flag moved on din change");
    @(posedge clk);
    hist = {hist[2:0], b};
    #1;
    h = hit;
    exp = (hist == 4'b1011);
    check(h, exp, exp ? "R1" : "R2", "flag vs window model");
    #2;
    check(hit, h, "R6", "flag moved between edges");
  endtask

  task automatic feed(input logic [15:0] bits, input int n, input logic [15:0] mask,
                      input string tag);
    logic h;
    for (int i = n - 1; i >= 0; i--) begin
      step(bits[i], h);
      check(h, mask[i], tag, "directed pulse position");
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    din = 1'b0;
    #1;
    check(hit, 1'b0, "R5", "flag during reset");
    @(negedge clk);
    rst_n = 1'b1;
    hist = 4'b0000;
    // zeros keep the model valid while the release propagates
    for (int i = 0; i < int'(SYNC) + 3; i++) begin
      logic h;
      step(1'b0, h);
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    #10;
    check(hit, 1'b0, "R5", "flag in reset");
    do_reset();

    // R3: overlapping occurrences
    feed(16'b0000, 4, 16'b0000, "R3");
    feed(16'b1011011, 7, 16'b0001001, "R3");
    // R4: completing 1 starts the next attempt
    feed(16'b0000, 4, 16'b0000, "R4");
    feed(16'b10111011, 8, 16'b00010001, "R4");
    feed(16'b0000, 4, 16'b0000, "R4");
    feed(16'b10110011, 8, 16'b00010000, "R4");
    // R7: self-overlap of partial progress
    feed(16'b0000, 4, 16'b0000, "R7");
    feed(16'b11011, 5, 16'b00001, "R7");
    feed(16'b0000, 4, 16'b0000, "R7");
    feed(16'b10011, 5, 16'b00000, "R7");
    feed(16'b0000, 4, 16'b0000, "R7");
    feed(16'b101011, 6, 16'b000001, "R7");

    // R5: reset in the middle of 1,0,1 forgets it
    feed(16'b101, 3, 16'b000, "R5");
    do_reset();
    feed(16'b1, 1, 16'b0, "R5");
    feed(16'b1, 1, 16'b0, "R5");

    // R1/R2: every 12-bit word streamed back to back
    for (int w = 0; w < 4096; w++) begin
      for (int b = 11; b >= 0; b--) begin
        logic h;
        step(w[b], h);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule